// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

This block is a 32-pin general purpose I/O bank driven through a flat register port (write enable, byte address, write data, read data). Every pad input passes through a two-flop synchronizer. The bank holds an output latch that drives the pads, a per-pin direction mask that drives the pad output enables, and a per-pin interrupt detector. Each detector has an enable bit, three configuration bits that select one of five trigger modes, and a sticky status bit that is cleared by writing one to it. A single interrupt line reports whether any enabled status bit is set.

Reading the value register always returns the synchronized pad level, even for a pin that is being driven as an output. Software that needs to know what it last wrote reads a separate read-only latch register instead. The pad drivers themselves sit outside the block and are modelled as an output-enable vector and an output-data vector.

Top module: `gpio_bank_irq`

## Requirements
- R1: After synchronous reset every register reads zero, pad_oe and pad_out are all zero and irq is low.
- R2: A read at byte offset 0x00 returns the pad level delayed by exactly two clock edges through the synchronizer, regardless of direction, so a write to 0x00 is not visible there unless the pads carry the same value.
- R3: A write at 0x00 loads the output latch, which drives pad_out on the next cycle and reads back at 0x08; a write at 0x08 changes nothing.
- R4: The direction mask sits at 0x04, four bytes above the value register; bit value 1 makes that pin an output (pad_oe bit high) and 0 an input.
- R5: Rising-edge mode (level bit 0, polarity bit 1, any-edge bit 0) sets the pin's status bit on the third clock edge after the pad rises and never on a fall.
- R6: Falling-edge mode (level 0, polarity 0, any-edge 0) sets the status bit on a fall and not on a rise.
- R7: With level bit 0 and any-edge bit 1 both transitions set the status bit, whatever the polarity bit holds.
- R8: With level bit 1 the status bit is set on every cycle in which the synchronized pin equals the polarity bit (1 high, 0 low), so clearing it while the level holds has no lasting effect.
- R9: The status register at 0x20 is write-one-to-clear per bit; zero bits in the write data leave status unchanged.
- R10: irq is high exactly when some status bit is set with its enable bit (0x10) set; status bits are captured even while their enable bit is clear.
- R11: The configuration registers are level select at 0x14, polarity at 0x18 and any-edge at 0x1C; any unmapped word address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Pad output enables (direction mask) |
| pad_out | output | 32 | Pad output data (output latch) |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted synchronizer or previous-sample register shows as a value read that arrives one edge early or late, or as a status bit that appears on the wrong transition within three cycles of the pad change. A wrong mode decode or a broken clear path shows on the next status read after the stimulus, and a broken enable gate shows on irq in the cycle after status or enable settles. Latch and direction faults are visible on pad_out and pad_oe one cycle after the write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_VALUE   = 6'h00;
    localparam logic [REG_AW-1:0] OFS_DIR     = 6'h04;
    localparam logic [REG_AW-1:0] OFS_LATCH   = 6'h08;
    localparam logic [REG_AW-1:0] OFS_IEN     = 6'h10;
    localparam logic [REG_AW-1:0] OFS_LVL     = 6'h14;
    localparam logic [REG_AW-1:0] OFS_POL     = 6'h18;
    localparam logic [REG_AW-1:0] OFS_ANY     = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_ISTAT   = 6'h20;

    typedef enum logic [2:0] {
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH,
        TRIG_LOW,
        TRIG_HIGH
    } trig_mode_e;

    typedef struct packed {
        logic lvl;
        logic pol;
        logic any;
    } trig_cfg_t;

    function automatic trig_mode_e decode_trig(trig_cfg_t c);
        if (c.lvl)      return c.pol ? TRIG_HIGH : TRIG_LOW;
        else if (c.any) return TRIG_BOTH;
        else            return c.pol ? TRIG_RISE : TRIG_FALL;
    endfunction

    function automatic logic trig_hit(trig_mode_e m, logic cur, logic prev);
        case (m)
            TRIG_RISE: return cur & ~prev;
            TRIG_FALL: return ~cur & prev;
            TRIG_BOTH: return cur ^ prev;
            TRIG_HIGH: return cur;
            TRIG_LOW:  return ~cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  latch_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  ien_q,
    output logic [NPINS-1:0]  lvl_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  any_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            ien_q   <= '0;
            lvl_q   <= '0;
            pol_q   <= '0;
            any_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_VALUE: latch_q <= wdata;
                OFS_DIR:   dir_q   <= wdata;
                OFS_IEN:   ien_q   <= wdata;
                OFS_LVL:   lvl_q   <= wdata;
                OFS_POL:   pol_q   <= wdata;
                OFS_ANY:   any_q   <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] any,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status_q
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] hit;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        trig_cfg_t  cfg;
        trig_mode_e mode;
        always_comb begin
            cfg    = '{lvl: lvl[p], pol: pol[p], any: any[p]};
            mode   = decode_trig(cfg);
            hit[p] = trig_hit(mode, pin_sync[p], prev_q[p]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= pin_sync;
            status_q <= (status_q & ~clr_mask) | hit;
        end
    end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic              irq
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] latch_q, dir_q, ien_q, lvl_q, pol_q, any_q;
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] clr_mask;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (pin_sync)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .ien_q   (ien_q),
        .lvl_q   (lvl_q),
        .pol_q   (pol_q),
        .any_q   (any_q)
    );

    assign clr_mask = (wr_en && addr == OFS_ISTAT) ? wdata : '0;

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pin_sync),
        .lvl      (lvl_q),
        .pol      (pol_q),
        .any      (any_q),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    always_comb begin
        case (addr)
            OFS_VALUE: rdata = pin_sync;
            OFS_DIR:   rdata = dir_q;
            OFS_LATCH: rdata = latch_q;
            OFS_IEN:   rdata = ien_q;
            OFS_LVL:   rdata = lvl_q;
            OFS_POL:   rdata = pol_q;
            OFS_ANY:   rdata = any_q;
            OFS_ISTAT: rdata = status_q;
            default:   rdata = '0;
        endcase
    end

    assign pad_oe  = dir_q;
    assign pad_out = latch_q;
    assign irq     = |(status_q & ien_q);
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [NPINS-1:0]  wdata,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  ien_q,
    input logic              irq
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && !irq));

    assert_latch_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_VALUE) |=> pad_out == $past(wdata));

    assert_latch_ro_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_LATCH) |=> $stable(pad_out));

    assert_dir_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_DIR) |=> pad_oe == $past(wdata));

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_q != '0));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .ien_q   (ien_q),
    .irq     (irq)
);

// File: tb/gpio_bank_irq_test.sv
module gpio_bank_irq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] cfg_lvl = '0, cfg_pol = '0, cfg_any = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_irq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg();
        wr(6'h18, cfg_pol);
        wr(6'h1C, cfg_any);
        wr(6'h14, cfg_lvl);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(6'h00, d); chk("R1 value", d, 32'h0);
        rd(6'h04, d); chk("R1 dir", d, 32'h0);
        rd(6'h08, d); chk("R1 latch", d, 32'h0);
        rd(6'h20, d); chk("R1 status", d, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_value_latch();
        logic [31:0] d;
        set_pad(32'hA5A5_0F0F);
        idle(1);
        rd(6'h00, d); chk("R2 one edge still old", d, 32'h0);
        idle(1);
        rd(6'h00, d); chk("R2 after two edges", d, 32'hA5A5_0F0F);
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h00, 32'hFFFF_0000);
        rd(6'h00, d); chk("R2 output mode reads pad", d, 32'hA5A5_0F0F);
        rd(6'h08, d); chk("R3 latch readback", d, 32'hFFFF_0000);
        chk("R3 pad_out", pad_out, 32'hFFFF_0000);
        wr(6'h08, 32'h0000_1234);
        rd(6'h08, d); chk("R3 latch write ignored", d, 32'hFFFF_0000);
        chk("R3 pad_out unchanged", pad_out, 32'hFFFF_0000);
        wr(6'h04, 32'h0000_00FF);
        chk("R4 pad_oe", pad_oe, 32'h0000_00FF);
        rd(6'h04, d); chk("R4 dir readback", d, 32'h0000_00FF);
        rd(6'h0C, d); chk("R11 unmapped 0x0C", d, 32'h0);
        rd(6'h3C, d); chk("R11 unmapped 0x3C", d, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        set_pad(32'h0); idle(4);
        cfg_pol[3] = 1'b1; write_cfg();
        rd(6'h18, d); chk("R11 polarity readback", d, 32'h0000_0008);
        wr(6'h10, 32'h0000_0008);
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, d); chk("R9 cleared all", d, 32'h0);
        set_pad(32'h0000_0008);
        idle(2);
        rd(6'h20, d); chk("R5 not yet after two edges", d, 32'h0);
        chk("R10 irq low before status", {31'h0, irq}, 32'h0);
        idle(1);
        rd(6'h20, d); chk("R5 rise sets status", d, 32'h0000_0008);
        chk("R10 irq high", {31'h0, irq}, 32'h1);
        wr(6'h20, 32'h0000_0000);
        rd(6'h20, d); chk("R9 zero write keeps", d, 32'h0000_0008);
        wr(6'h20, 32'h0000_0008);
        rd(6'h20, d); chk("R9 one write clears", d, 32'h0);
        chk("R10 irq low after clear", {31'h0, irq}, 32'h0);
        set_pad(32'h0); idle(4);
        rd(6'h20, d); chk("R5 fall ignored", d, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        set_pad(32'h0000_0010); idle(4);
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, d); chk("R6 rise ignored", d, 32'h0);
        set_pad(32'h0); idle(3);
        rd(6'h20, d); chk("R6 fall sets status", d, 32'h0000_0010);
        wr(6'h20, 32'hFFFF_FFFF);
    endtask

    task automatic t_both();
        logic [31:0] d;
        cfg_any[5] = 1'b1; write_cfg();
        wr(6'h20, 32'hFFFF_FFFF);
        set_pad(32'h0000_0020); idle(3);
        rd(6'h20, d); chk("R7 rise with polarity 0", d, 32'h0000_0020);
        wr(6'h20, 32'hFFFF_FFFF);
        set_pad(32'h0); idle(3);
        rd(6'h20, d); chk("R7 fall", d, 32'h0000_0020);
        wr(6'h20, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] d;
        cfg_pol[6] = 1'b1; cfg_lvl[6] = 1'b1; write_cfg();
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, d); chk("R8 high idle", d, 32'h0);
        set_pad(32'h0000_0040); idle(3);
        rd(6'h20, d); chk("R8 level high sets", d, 32'h0000_0040);
        wr(6'h20, 32'h0000_0040);
        rd(6'h20, d); chk("R8 re-set while held", d, 32'h0000_0040);
        set_pad(32'h0000_0080); idle(3);
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, d); chk("R8 high released", d, 32'h0);
        cfg_lvl[7] = 1'b1; write_cfg();
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, d); chk("R8 low idle while pad high", d, 32'h0);
        set_pad(32'h0); idle(3);
        rd(6'h20, d); chk("R8 level low sets", d, 32'h0000_0080);
        chk("R10 masked status no irq", {31'h0, irq}, 32'h0);
        wr(6'h10, 32'h0000_0080);
        chk("R10 enable raises irq", {31'h0, irq}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_value_latch();
        t_rise();
        t_fall();
        t_both();
        t_level();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule